// File: doc/BRIEF.md
# Frame-Synchronous Shadow Configuration Bank

This block holds the configuration words of several display-pipeline stages. Each stage owns a pair of registers. Software writes reach only the staged (shadow) copy. The live (active) copy, which drives the stage, changes only on a commit event. A two-bit policy field sets where commit events fall relative to the vertical-sync strobe, the frame-end strobe and writes to the run register. A 64-bit freeze mask, held as two 32-bit words, holds chosen stages on their old live value while the other stages move on.

Writing 1 to the run register starts the pipe when it is stopped. When it is already running, the same write flushes: every staged value that is not frozen is committed at once. On a commit, every stage that is not frozen and has a staged value waiting takes it on the same clock edge. Each such stage raises a one-cycle update pulse. A status bit shows whether any staged value is still waiting.

Top module: `shreg_bank`

## Requirements
- R1: After reset every live word reads 0, both freeze words read all ones, the policy field reads 0, the run bit reads 0, the status bit reads 0 and no update pulse is high.
- R2: A write to staged address 8+k (k = 0..4) does not change live word k. Reading that address returns the staged value. Status bit 0 (address 4) reads 1 while any staged value is waiting.
- R3: Policy 0 (control address 0, bits [1:0]): while running, each vsync strobe commits. Frame-end strobes do not commit.
- R4: Policy 1: the run write that starts the pipe commits, and after that every frame-end strobe commits. Vsync does not commit.
- R5: Policy 2: only writes of 1 to the run register (address 1, bit 0) commit. Vsync and frame-end strobes do not.
- R6: Policy 3: after the pipe starts, the first vsync commits and later vsyncs do not. Frame-end strobes commit only after that first vsync.
- R7: Writing 1 to the run register while the pipe is already running commits at once, under any policy.
- R8: No commit happens while the pipe is stopped. A write of 0 to the run register suppresses any commit in that same cycle.
- R9: Stage k is frozen by freeze bit N(k), with N = 0, 15, 21, 24, 37 for k = 0..4. Bit N sits in word N/32 (address 2 for word 0, address 3 for word 1) at position N mod 32. A frozen stage keeps its live word and its waiting flag across commits. Once the bit is cleared, the next commit applies the staged value.
- R10: On a commit edge, every stage that is not frozen and has a staged value waiting updates on that same edge. Its update pulse is high for exactly the one cycle after that edge. Live words change at no other time.
- R11: The status bit returns to 0 after a commit that drains every waiting stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| vsync | input | 1 | Vertical-sync strobe, one cycle |
| frame_end | input | 1 | Frame-end strobe, one cycle |
| active_cfg | output | NUM_SUB*DATA_W | Live words, stage k in slice k |
| updated | output | NUM_SUB | One-cycle pulse per stage that took a new value |

## Verification
The bench aims at the first-event rules of policies 1 and 3. A design that treats the first vsync and the later frame ends the same way would either commit on every vsync or wait too long before its first update. It maps each freeze position across the 32-bit word boundary, including bit 37 in the upper word. A design that splits the bit number wrongly would freeze the wrong stage, and that stage would update while its neighbour did not. It also stops the pipe in the same cycle as a vsync and flushes while running. A design with the wrong priority on the run register would update when stopped, or ignore the flush.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
   typedef enum logic [1:0] {
      POL_VSYNC        = 2'd0,
      POL_RUN_FEND     = 2'd1,
      POL_RUN_ONLY     = 2'd2,
      POL_VSYNC1_FEND  = 2'd3
   } policy_e;

   localparam int unsigned NUM_SUB   = 5;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned FRZ_BITS  = 2 * WORD_W;

   localparam int unsigned A_CTRL    = 0;
   localparam int unsigned A_RUN     = 1;
   localparam int unsigned A_FRZ0    = 2;
   localparam int unsigned A_FRZ1    = 3;
   localparam int unsigned A_STATUS  = 4;
   localparam int unsigned A_STAGE   = 8;

   function automatic int unsigned frz_pos(input int unsigned k);
      case (k)
         0: frz_pos = 0;
         1: frz_pos = 15;
         2: frz_pos = 21;
         3: frz_pos = 24;
         4: frz_pos = 37;
         default: frz_pos = 0;
      endcase
   endfunction
endpackage

// File: rtl/shreg_commit_ctrl.sv
module shreg_commit_ctrl
   import shreg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  policy_e policy,
   input  logic    run_wr,
   input  logic    run_bit,
   input  logic    vsync,
   input  logic    frame_end,
   output logic    run,
   output logic    commit
);
   logic first_seen;
   logic start, flush, stop, sched;

   always_comb begin
      start = run_wr &  run_bit & ~run;
      flush = run_wr &  run_bit &  run;
      stop  = run_wr & ~run_bit;
      unique case (policy)
         POL_VSYNC:       sched = run & vsync;
         POL_RUN_FEND:    sched = start | (run & frame_end);
         POL_RUN_ONLY:    sched = start;
         POL_VSYNC1_FEND: sched = run & (first_seen ? frame_end : vsync);
         default:         sched = 1'b0;
      endcase
      commit = (flush | sched) & ~stop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         first_seen <= 1'b0;
      end else begin
         if (start)     run <= 1'b1;
         else if (stop) run <= 1'b0;
         if (start | stop)     first_seen <= 1'b0;
         else if (run & vsync) first_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/shreg_freeze_map.sv
module shreg_freeze_map
   import shreg_pkg::*;
(
   input  logic [WORD_W-1:0]  frz_lo,
   input  logic [WORD_W-1:0]  frz_hi,
   output logic [NUM_SUB-1:0] frozen
);
   for (genvar k = 0; k < NUM_SUB; k++) begin : g_map
      localparam int unsigned POS = frz_pos(k);
      localparam int unsigned WRD = POS / WORD_W;
      localparam int unsigned BIT = POS % WORD_W;
      if (POS >= FRZ_BITS) begin : g_bad
         $error("freeze position out of range");
      end
      if (WRD == 0) begin : g_lo
         assign frozen[k] = frz_lo[BIT];
      end else begin : g_hi
         assign frozen[k] = frz_hi[BIT];
      end
   end
endmodule

// File: rtl/shreg_slot.sv
module shreg_slot #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic              frozen,
   output logic [DATA_W-1:0] shadow,
   output logic [DATA_W-1:0] active,
   output logic              pending,
   output logic              updated
);
   logic take;
   assign take = commit & ~frozen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow  <= '0;
         active  <= '0;
         pending <= 1'b0;
         updated <= 1'b0;
      end else begin
         if (wr)   shadow <= wdata;
         if (take) active <= shadow;
         pending <= (pending & ~take) | wr;
         updated <= take & pending;
      end
   end
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
   import shreg_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter logic [63:0] FRZ_RESET = '1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [31:0]               bus_wdata,
   output logic [31:0]               bus_rdata,
   input  logic                      vsync,
   input  logic                      frame_end,
   output logic [NUM_SUB*DATA_W-1:0] active_cfg,
   output logic [NUM_SUB-1:0]        updated
);
   if (DATA_W < 1 || DATA_W > WORD_W) begin : g_bad_w
      $error("DATA_W must be 1..32");
   end
   if (A_STAGE + NUM_SUB > (1 << ADDR_W)) begin : g_bad_a
      $error("ADDR_W too small for the stage window");
   end

   policy_e              pol_q;
   logic [WORD_W-1:0]    frz_lo, frz_hi;
   logic [NUM_SUB-1:0]   frozen, pending, sh_wr;
   logic [DATA_W-1:0]    shadow [NUM_SUB];
   logic                 run, commit, run_wr;

   assign run_wr = bus_wr && (bus_addr == ADDR_W'(A_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= POL_VSYNC;
         frz_lo <= FRZ_RESET[31:0];
         frz_hi <= FRZ_RESET[63:32];
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(A_CTRL)) pol_q  <= policy_e'(bus_wdata[1:0]);
         if (bus_addr == ADDR_W'(A_FRZ0)) frz_lo <= bus_wdata;
         if (bus_addr == ADDR_W'(A_FRZ1)) frz_hi <= bus_wdata;
      end
   end

   shreg_commit_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .policy(pol_q), .run_wr(run_wr),
      .run_bit(bus_wdata[0]), .vsync(vsync), .frame_end(frame_end),
      .run(run), .commit(commit)
   );

   shreg_freeze_map u_map (
      .frz_lo(frz_lo), .frz_hi(frz_hi), .frozen(frozen)
   );

   for (genvar k = 0; k < NUM_SUB; k++) begin : g_slot
      assign sh_wr[k] = bus_wr && (bus_addr == ADDR_W'(A_STAGE + k));
      shreg_slot #(.DATA_W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(sh_wr[k]),
         .wdata(bus_wdata[DATA_W-1:0]), .commit(commit), .frozen(frozen[k]),
         .shadow(shadow[k]), .active(active_cfg[k*DATA_W +: DATA_W]),
         .pending(pending[k]), .updated(updated[k])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = {30'd0, pol_q};
      if (bus_addr == ADDR_W'(A_RUN))    bus_rdata = {31'd0, run};
      if (bus_addr == ADDR_W'(A_FRZ0))   bus_rdata = frz_lo;
      if (bus_addr == ADDR_W'(A_FRZ1))   bus_rdata = frz_hi;
      if (bus_addr == ADDR_W'(A_STATUS)) bus_rdata = {31'd0, |pending};
      for (int k = 0; k < NUM_SUB; k++)
         if (bus_addr == ADDR_W'(A_STAGE + k)) bus_rdata = 32'(shadow[k]);
   end
endmodule

// File: rtl/shreg_bank_chk.sv
module shreg_bank_chk
   import shreg_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      commit,
   input logic                      run,
   input logic                      run_wr,
   input logic                      vsync,
   input logic [1:0]                policy,
   input logic [NUM_SUB-1:0]        frozen,
   input logic [NUM_SUB-1:0]        pending,
   input logic [NUM_SUB-1:0]        sh_wr,
   input logic [NUM_SUB-1:0]        updated,
   input logic [NUM_SUB*DATA_W-1:0] active_cfg
);
   p_hold_no_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit) |-> $stable(active_cfg));

   p_idle_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !run_wr) |-> !commit);

   p_pol0_vsync_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && policy == 2'd0 && !vsync && !run_wr) |-> !commit);

   for (genvar k = 0; k < NUM_SUB; k++) begin : g_k
      p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
         updated[k] |-> ($past(commit) && !$past(frozen[k])));

      p_frozen_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(frozen[k]) |-> $stable(active_cfg[k*DATA_W +: DATA_W]));

      p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(commit) && !$past(frozen[k]) && !$past(sh_wr[k])) |-> !pending[k]);
   end
endmodule

bind shreg_bank shreg_bank_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .run(run), .run_wr(run_wr),
   .vsync(vsync), .policy(pol_q), .frozen(frozen), .pending(pending),
   .sh_wr(sh_wr), .updated(updated), .active_cfg(active_cfg)
);

// File: tb/shreg_bank_tb.sv
module shreg_bank_tb;
   localparam int NS = 5;
   logic        clk = 0, rst_n = 0;
   logic        bus_wr = 0, vsync = 0, frame_end = 0;
   logic [3:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [NS*32-1:0] active_cfg;
   logic [NS-1:0]    updated;
   int nchk = 0, nfail = 0;

   always #5 clk = ~clk;

   shreg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vsync(vsync),
      .frame_end(frame_end), .active_cfg(active_cfg), .updated(updated)
   );

   function automatic logic [31:0] act(input int k);
      return active_cfg[k*32 +: 32];
   endfunction

   task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
      nchk++;
      if (a !== e) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, a, e);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic vs();
      @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
   endtask

   task automatic fe();
      @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int k = 0; k < NS; k++) check("R1 live word", act(k), 0);
      rd(2, d); check("R1 freeze word0", d, 32'hFFFF_FFFF);
      rd(3, d); check("R1 freeze word1", d, 32'hFFFF_FFFF);
      rd(0, d); check("R1 policy", d, 0);
      rd(1, d); check("R1 run", d, 0);
      rd(4, d); check("R1 status", d, 0);
      check("R1 pulses", 32'(updated), 0);
   endtask

   task automatic t_pol0();
      logic [31:0] d;
      wr(2, 0); wr(3, 0); wr(0, 0);
      wr(8, 32'hA);
      check("R2 live unchanged", act(0), 0);
      rd(8, d); check("R2 staged readback", d, 32'hA);
      rd(4, d); check("R2 status waiting", d, 1);
      wr(1, 1); check("R3 start no commit", act(0), 0);
      fe();     check("R3 frame end ignored", act(0), 0);
      vs();     check("R3 vsync commit", act(0), 32'hA);
      check("R10 pulse", 32'(updated), 32'b00001);
      rd(4, d); check("R11 status drained", d, 0);
      @(negedge clk); check("R10 pulse one cycle", 32'(updated), 0);
      wr(1, 0); wr(9, 32'hB);
      vs(); check("R8 stopped no commit", act(1), 0);
   endtask

   task automatic t_pol1();
      wr(0, 1);
      wr(1, 1); check("R4 start commits", act(1), 32'hB);
      wr(10, 32'hC);
      vs(); check("R4 vsync ignored", act(2), 0);
      fe(); check("R4 frame end commits", act(2), 32'hC);
      wr(11, 32'hD);
      wr(1, 1); check("R7 flush commits", act(3), 32'hD);
      wr(1, 0);
   endtask

   task automatic t_pol2();
      wr(0, 2); wr(8, 32'hE);
      wr(1, 1); check("R5 start commits", act(0), 32'hE);
      wr(8, 32'hF);
      vs(); fe(); check("R5 strobes ignored", act(0), 32'hE);
      wr(1, 1); check("R5 run write commits", act(0), 32'hF);
      wr(1, 0);
   endtask

   task automatic t_pol3();
      wr(0, 3); wr(12, 32'h6);
      wr(1, 1); check("R6 start no commit", act(4), 0);
      fe(); check("R6 frame end before vsync", act(4), 0);
      vs(); check("R6 first vsync commits", act(4), 32'h6);
      wr(12, 32'h7);
      vs(); check("R6 later vsync ignored", act(4), 32'h6);
      fe(); check("R6 frame end commits", act(4), 32'h7);
   endtask

   task automatic t_freeze();
      logic [31:0] d;
      wr(2, 32'h1 << 15); wr(3, 32'h1 << 5);
      wr(9, 32'h11); wr(12, 32'h44); wr(10, 32'h22);
      wr(1, 1);
      check("R9 stage2 free", act(2), 32'h22);
      check("R9 stage1 bit15 frozen", act(1), 32'hB);
      check("R9 stage4 bit37 frozen", act(4), 32'h7);
      check("R10 pulse subset", 32'(updated), 32'b00100);
      rd(4, d); check("R9 frozen still waiting", d, 1);
      wr(2, 0); wr(3, 0);
      wr(1, 1);
      check("R9 release stage1", act(1), 32'h11);
      check("R9 release stage4", act(4), 32'h44);
      check("R10 same-edge pulses", 32'(updated), 32'b10010);
      wr(2, 32'h1 << 24);
      wr(11, 32'h33); wr(8, 32'h55);
      wr(1, 1);
      check("R9 stage0 free", act(0), 32'h55);
      check("R9 stage3 bit24 frozen", act(3), 32'hD);
      wr(2, 32'h1 << 21); wr(1, 1);
      check("R9 stage3 released", act(3), 32'h33);
      wr(2, 0);
   endtask

   task automatic t_stop_same_cycle();
      wr(0, 0); wr(8, 32'h77);
      @(negedge clk); bus_wr = 1; bus_addr = 1; bus_wdata = 0; vsync = 1;
      @(negedge clk); bus_wr = 0; vsync = 0;
      check("R8 stop beats vsync", act(0), 32'h55);
      wr(1, 1); check("R8 restart no commit", act(0), 32'h55);
      vs(); check("R3 vsync after restart", act(0), 32'h77);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_pol0();
      t_pol1();
      t_pol2();
      t_pol3();
      t_freeze();
      t_stop_same_cycle();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule